// File: doc/BRIEF.md
# ULPI PHY Interface Guard Controller

This block sits on the PHY side of a ULPI link and decides what the PHY's interface pins do whenever the link is not in normal operation. It holds the direction line high through reset, then releases it a fixed number of clock cycles after reset ends. It tri-states every ULPI output while the part is deselected or powered down. It also engages weak pull-downs on the eight data lines when the stop line is seen high while the link is not driving the bus properly.

A one-bit protection-disable register, written through a single-bit write port, turns the data-line pull-downs off. The weak pull-up on the stop line is enabled at all times outside power-down. A registered reset output clears the PHY's register file. The reset input and the power-down input can each be tied to their idle level when unused.

Top module: `ulpi_guard_ctrl`

## Requirements
- R1: While `rst_n` is low, `dir_out` is 1 and `reg_rst` is 1, starting at once without waiting for a clock edge.
- R2: Take `rst_n` rising before clock edge 1, with power-down idle. `reg_rst` falls after edge 2. `dir_out` stays 1 through edge 3 and is 0 after edge 4.
- R3: While `pwr_dn` is 1, `dir_oe` and `ulpi_oe` are 0 and `pd_req` is 1, starting at once. This state holds until the second rising edge after `pwr_dn` returns to 0.
- R4: Take `pwr_dn` falling before edge 1, after a power-down of at least three cycles. `dir_out` is 1 through edge 3 and is 0 after edge 4.
- R5: `stp_pu_en` is 1 whenever power-down is not active, including during reset, and 0 while power-down is active.
- R6: While protection is enabled (protection bit 0), `data_pd_en` becomes 8'hFF after the second rising edge that samples `stp_in` high. It returns to 8'h00 after the second edge that samples it low. It is always either all ones or all zeros.
- R7: A write (`cfg_we` 1 at a rising edge) loads `cfg_wdata` into the protection bit, and the new value takes effect right after that edge. While the bit is 1, `data_pd_en` is 8'h00 whatever `stp_in` does.
- R8: The protection bit clears to 0 during reset. Writes presented while `reg_rst` is 1 are ignored.
- R9: Power-down takes priority over reset for the output enables. While power-down is inactive, `dir_oe` and `ulpi_oe` are 1, even while `rst_n` is low.
- R10: While `reg_rst` is 1 or power-down is active, `data_pd_en` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Active-low reset (tie high if unused) |
| pwr_dn | input | 1 | Deselect / power-down, active high (tie low if unused) |
| stp_in | input | 1 | Sensed level of the stop line |
| cfg_we | input | 1 | Write strobe for the protection-disable bit |
| cfg_wdata | input | 1 | Value written to the protection-disable bit |
| dir_out | output | 1 | Direction line level driven by the PHY |
| dir_oe | output | 1 | Output enable for the direction line |
| ulpi_oe | output | 1 | Tri-state enable for all other ULPI outputs |
| stp_pu_en | output | 1 | Weak pull-up enable on the stop line |
| data_pd_en | output | 8 | Weak pull-down enables, one per data line |
| pd_req | output | 1 | Power-down request to internal circuitry |
| reg_rst | output | 1 | Active-high reset to the ULPI register file |

## Verification
Several stop-line patterns are applied. A static high level and a static low level show the two-stage sampling latency. Pulses shorter than two cycles mixed with longer runs tell a correct two-flop path from one that is one stage short or too long. Protection-bit writes are made while the stop line is high, which separates the disable path from the sampling path, and writes made during reset show whether reset masks the write port. Power-down entry and exit, and a reset asserted in the middle of operation, each test the release count separately, so an error in the reset path cannot hide one in the power-down path.

// File: rtl/ugc_pkg.sv
package ugc_pkg;

    localparam int UGC_DATA_W      = 8;
    localparam int UGC_SYNC_STAGES = 2;
    localparam int UGC_REL_CYCLES  = 4;

    typedef enum logic [0:0] {
        REL_WAIT = 1'b0,
        REL_DONE = 1'b1
    } rel_state_e;

    typedef struct packed {
        logic dir_oe;
        logic ulpi_oe;
        logic stp_pu;
        logic pd_req;
    } pin_ctl_t;

    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    function automatic pin_ctl_t pin_ctl(input logic pd_active);
        pin_ctl_t p;
        p.dir_oe  = ~pd_active;
        p.ulpi_oe = ~pd_active;
        p.stp_pu  = ~pd_active;
        p.pd_req  = pd_active;
        return p;
    endfunction

endpackage

// File: rtl/ugc_sync.sv
module ugc_sync #(
    parameter int   STAGES    = 2,
    parameter bit   ASYNC_CLR = 1'b0,
    parameter logic CLR_VAL   = 1'b0
) (
    input  logic clk,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or posedge clr) begin
                if (clr) chain <= {STAGES{CLR_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (clr) chain <= {STAGES{CLR_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ugc_dir_release.sv
module ugc_dir_release
    import ugc_pkg::*;
#(
    parameter int WAIT = 2
) (
    input  logic clk,
    input  logic restart,
    input  logic rst_n,
    output logic dir_out
);
    localparam int CW = cnt_width(WAIT);

    rel_state_e    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (restart) begin
            state <= REL_WAIT;
            cnt   <= '0;
        end else if (state == REL_WAIT) begin
            if (cnt == CW'(WAIT - 1)) state <= REL_DONE;
            else                      cnt   <= cnt + CW'(1);
        end
    end

    // direction stays high until the count completes; the raw reset pin
    // forces it high without waiting for a clock edge
    assign dir_out = ~((state == REL_DONE) & rst_n);
endmodule

// File: rtl/ugc_pull_ctrl.sv
module ugc_pull_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              sync_rst,
    input  logic              cfg_we,
    input  logic              cfg_wdata,
    input  logic              stp_seen,
    input  logic              pd_active,
    output logic [DATA_W-1:0] data_pd_en
);
    logic prot_dis;

    always_ff @(posedge clk) begin
        if (sync_rst)    prot_dis <= 1'b0;
        else if (cfg_we) prot_dis <= cfg_wdata;
    end

    logic engage;
    assign engage = stp_seen & ~prot_dis & ~pd_active & ~sync_rst;

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_pd
            assign data_pd_en[i] = engage;
        end
    endgenerate
endmodule

// File: rtl/ulpi_guard_ctrl.sv
module ulpi_guard_ctrl
    import ugc_pkg::*;
#(
    parameter int DATA_W      = UGC_DATA_W,
    parameter int SYNC_STAGES = UGC_SYNC_STAGES,
    parameter int REL_CYCLES  = UGC_REL_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              stp_in,
    input  logic              cfg_we,
    input  logic              cfg_wdata,
    output logic              dir_out,
    output logic              dir_oe,
    output logic              ulpi_oe,
    output logic              stp_pu_en,
    output logic [DATA_W-1:0] data_pd_en,
    output logic              pd_req,
    output logic              reg_rst
);
    localparam int WAIT = REL_CYCLES - SYNC_STAGES;

    logic rst_ok;
    logic pwr_seen;
    logic stp_seen;
    logic sync_rst;
    logic pd_active;
    logic restart;
    pin_ctl_t pins;

    // reset: asynchronous assertion, synchronised release
    ugc_sync #(.STAGES(SYNC_STAGES), .ASYNC_CLR(1'b1), .CLR_VAL(1'b0)) u_rst_sync (
        .clk (clk),
        .clr (~rst_n),
        .d   (1'b1),
        .q   (rst_ok)
    );

    assign sync_rst = ~rst_ok;

    ugc_sync #(.STAGES(SYNC_STAGES), .ASYNC_CLR(1'b0), .CLR_VAL(1'b0)) u_pwr_sync (
        .clk (clk),
        .clr (sync_rst),
        .d   (pwr_dn),
        .q   (pwr_seen)
    );

    ugc_sync #(.STAGES(SYNC_STAGES), .ASYNC_CLR(1'b0), .CLR_VAL(1'b0)) u_stp_sync (
        .clk (clk),
        .clr (sync_rst),
        .d   (stp_in),
        .q   (stp_seen)
    );

    // the raw pin gates the enables at once; the synchronised copy holds
    // them off until the release sequence can start cleanly
    assign pd_active = pwr_dn | pwr_seen;
    assign restart   = sync_rst | pwr_seen;

    ugc_dir_release #(.WAIT(WAIT)) u_rel (
        .clk     (clk),
        .restart (restart),
        .rst_n   (rst_n),
        .dir_out (dir_out)
    );

    ugc_pull_ctrl #(.DATA_W(DATA_W)) u_pull (
        .clk        (clk),
        .sync_rst   (sync_rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .stp_seen   (stp_seen),
        .pd_active  (pd_active),
        .data_pd_en (data_pd_en)
    );

    assign pins      = pin_ctl(pd_active);
    assign dir_oe    = pins.dir_oe;
    assign ulpi_oe   = pins.ulpi_oe;
    assign stp_pu_en = pins.stp_pu;
    assign pd_req    = pins.pd_req;
    assign reg_rst   = sync_rst;
endmodule

// File: rtl/ugc_checker.sv
module ugc_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_dn,
    input logic              cfg_we,
    input logic              cfg_wdata,
    input logic              dir_out,
    input logic              dir_oe,
    input logic              ulpi_oe,
    input logic              stp_pu_en,
    input logic [DATA_W-1:0] data_pd_en,
    input logic              pd_req,
    input logic              reg_rst
);
    // sampled mid-cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            assert_dir_in_reset_R1: assert (dir_out === 1'b1 && reg_rst === 1'b1)
                else $error("direction or register reset not held during reset");
        end
        if (pwr_dn === 1'b1) begin
            assert_tristate_pd_R3: assert (dir_oe === 1'b0 && ulpi_oe === 1'b0 && pd_req === 1'b1)
                else $error("outputs not tri-stated in power-down");
        end
        if (pd_req === 1'b0) begin
            assert_pullup_idle_R5: assert (stp_pu_en === 1'b1)
                else $error("stop pull-up off outside power-down");
        end
    end

    assert_release_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(reg_rst) && !pd_req) |=> (dir_out ##1 !dir_out));

    assert_prot_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata && !reg_rst) |=> (data_pd_en == '0));

    assert_pd_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_pd_en == '0) || (data_pd_en == '1));

    assert_pd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rst || pd_req) |-> (data_pd_en == '0));
endmodule

bind ulpi_guard_ctrl ugc_checker #(.DATA_W(DATA_W)) u_ugc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_dn     (pwr_dn),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .dir_out    (dir_out),
    .dir_oe     (dir_oe),
    .ulpi_oe    (ulpi_oe),
    .stp_pu_en  (stp_pu_en),
    .data_pd_en (data_pd_en),
    .pd_req     (pd_req),
    .reg_rst    (reg_rst)
);

// File: tb/ulpi_guard_ctrl_test.sv
`timescale 1ns/1ps
module ulpi_guard_ctrl_test;
    localparam int SYNC = 2;
    localparam int WAIT = 2;

    logic       clk = 1'b0;
    logic       rst_n, pwr_dn, stp_in, cfg_we, cfg_wdata;
    logic       dir_out, dir_oe, ulpi_oe, stp_pu_en, pd_req, reg_rst;
    logic [7:0] data_pd_en;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ulpi_guard_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .stp_in(stp_in),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .dir_out(dir_out),
        .dir_oe(dir_oe), .ulpi_oe(ulpi_oe), .stp_pu_en(stp_pu_en),
        .data_pd_en(data_pd_en), .pd_req(pd_req), .reg_rst(reg_rst)
    );

    // behavioural reference: edge counters and sample histories
    int rcnt = 0;
    int dcnt = 0;
    bit pwr_q[$] = '{0, 0};
    bit stp_q[$] = '{0, 0};
    bit prot = 0;

    always @(posedge clk) begin
        bit ok_old;
        ok_old = rst_n && (rcnt >= SYNC);
        if (!ok_old || pwr_q[0]) dcnt = 0;
        else if (dcnt < WAIT)    dcnt++;
        if (!ok_old) begin
            pwr_q = '{0, 0};
            stp_q = '{0, 0};
            prot  = 0;
        end else begin
            void'(pwr_q.pop_front());
            pwr_q.push_back(pwr_dn);
            void'(stp_q.pop_front());
            stp_q.push_back(stp_in);
            if (cfg_we) prot = cfg_wdata;
        end
        if (!rst_n)          rcnt = 0;
        else if (rcnt < SYNC) rcnt++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit pd, ok_now;
        pd     = pwr_dn || pwr_q[0];
        ok_now = rst_n && (rcnt >= SYNC);
        chk("R1/R2/R4 dir_out", dir_out, !(rst_n && dcnt >= WAIT));
        chk("R3/R9 dir_oe", dir_oe, !pd);
        chk("R3/R9 ulpi_oe", ulpi_oe, !pd);
        chk("R3 pd_req", pd_req, pd);
        chk("R5 stp_pu_en", stp_pu_en, !pd);
        chk("R6/R7/R10 data_pd_en", data_pd_en,
            (stp_q[0] && !prot && !pd && ok_now) ? 8'hFF : 8'h00);
        chk("R1/R2 reg_rst", reg_rst, !ok_now);
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst_n = 0; pwr_dn = 0; stp_in = 0; cfg_we = 0; cfg_wdata = 0;
        tick(5);
        chk("R1 dir high in reset", dir_out, 1);
        chk("R1 reg_rst in reset", reg_rst, 1);
        chk("R9 oe on during reset", ulpi_oe, 1);
        chk("R5 pull-up during reset", stp_pu_en, 1);

        rst_n = 1;
        tick(1); chk("R2 reg_rst after edge 1", reg_rst, 1);
        tick(1); chk("R2 reg_rst after edge 2", reg_rst, 0);
        chk("R2 dir after edge 2", dir_out, 1);
        tick(1); chk("R2 dir after edge 3", dir_out, 1);
        tick(1); chk("R2 dir after edge 4", dir_out, 0);

        stp_in = 1;
        tick(1); chk("R6 one edge of stp high", data_pd_en, 8'h00);
        tick(1); chk("R6 two edges of stp high", data_pd_en, 8'hFF);
        stp_in = 0;
        tick(1); chk("R6 one edge of stp low", data_pd_en, 8'hFF);
        tick(1); chk("R6 two edges of stp low", data_pd_en, 8'h00);

        stp_in = 1; tick(3);
        cfg_we = 1; cfg_wdata = 1;
        tick(1); cfg_we = 0;
        chk("R7 disable takes effect", data_pd_en, 8'h00);
        tick(4); chk("R7 disabled with stp high", data_pd_en, 8'h00);
        cfg_we = 1; cfg_wdata = 0;
        tick(1); cfg_we = 0;
        chk("R7 re-enable", data_pd_en, 8'hFF);

        pwr_dn = 1; #1;
        chk("R3 ulpi_oe immediate", ulpi_oe, 0);
        chk("R3 dir_oe immediate", dir_oe, 0);
        chk("R3 pd_req immediate", pd_req, 1);
        chk("R10 pull-downs off in power-down", data_pd_en, 8'h00);
        tick(5);
        pwr_dn = 0;
        tick(1); chk("R3 hold after exit edge 1", ulpi_oe, 0);
        tick(1); chk("R3 oe back after edge 2", ulpi_oe, 1);
        chk("R4 dir after edge 2", dir_out, 1);
        tick(1); chk("R4 dir after edge 3", dir_out, 1);
        tick(1); chk("R4 dir after edge 4", dir_out, 0);

        cfg_we = 1; cfg_wdata = 1; tick(1); cfg_we = 0;
        rst_n = 0; #1;
        chk("R1 dir immediate on reset", dir_out, 1);
        chk("R1 reg_rst immediate", reg_rst, 1);
        chk("R10 pull-downs off in reset", data_pd_en, 8'h00);
        tick(1);
        cfg_we = 1; cfg_wdata = 1;
        tick(3);
        cfg_we = 0;
        rst_n = 1;
        tick(6);
        chk("R8 write in reset ignored", data_pd_en, 8'hFF);

        pwr_dn = 1; rst_n = 0;
        tick(2);
        chk("R9 power-down beats reset", ulpi_oe, 0);
        rst_n = 1; tick(3); pwr_dn = 0; tick(8);

        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            stp_in    = lfsr[0];
            cfg_we    = (lfsr[5:3] == 3'b000);
            cfg_wdata = lfsr[7];
            tick(1);
        end
        cfg_we = 0;
        tick(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule